// File: doc/BRIEF.md
# Sleep Down-Timer

This block holds the remaining run time of a clock radio's sleep function and drives the output that keeps the radio powered. The time is kept as hours (0 or 1) and two BCD minute digits, so the display path can show it directly. Entering the sleep view loads a preset: 0:59 normally, or 1:59 when the hour button is held as the view is entered.

Once loaded, the timer counts down one minute per minute tick. While the sleep view is shown and the minute button is held, alone or together with the hour button, it also counts down on every 2 Hz tick, so the user can trim the preset. A snooze press clears the timer, but only when no alarm is sounding. During a snooze press with an active alarm, the press belongs to the alarm logic and the timer ignores it. The timer stops at 0:00, and the sleep output is high whenever the value is nonzero.

Top module: `sleep_down_timer`

## Requirements
- R1: A rising edge of `sleep_view` with `hour_btn` low loads 0:59 (`hours`=0, `min_tens`=5, `min_ones`=9). The new value appears after the next clock edge.
- R2: A rising edge of `sleep_view` with `hour_btn` high loads 1:59.
- R3: While `sleep_view` and `min_btn` are high (`hour_btn` may also be high), each cycle with `tick_2hz` high decrements the value by one minute.
- R4: Each cycle with `min_tick` high decrements the value by one minute, in any view. A cycle that has both a minute tick and a fast tick decrements only once.
- R5: `sleep_on` is high exactly when the registered value is not 0:00.
- R6: `snooze_btn` high with `alarm_on` low clears the value to 0:00 on the next edge. This clear takes priority over loading and counting.
- R7: `snooze_btn` high with `alarm_on` high leaves the value unchanged.
- R8: The value never goes below 0:00. A tick at 0:00 leaves it at 0:00.
- R9: When the minutes are 00, a decrement borrows from the hour, so 1:00 becomes 0:59. Minute digits always stay in the range 0-5 and 0-9.
- R10: `blank_hr_tens` equals `sleep_view`, so the leading digit is blanked in the sleep view.
- R11: Holding `hour_btn` alone after entering the view has no effect on the value, even on 2 Hz ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears the timer |
| sleep_view | input | 1 | Sleep display view selected |
| hour_btn | input | 1 | Hour set button, level |
| min_btn | input | 1 | Minute set button, level |
| snooze_btn | input | 1 | Snooze button, level |
| alarm_on | input | 1 | Alarm currently sounding |
| min_tick | input | 1 | One-cycle pulse per minute |
| tick_2hz | input | 1 | One-cycle pulse at 2 Hz |
| hours | output | 1 | Hour digit of remaining time |
| min_tens | output | 3 | Tens of minutes, BCD 0-5 |
| min_ones | output | 4 | Units of minutes, BCD 0-9 |
| sleep_on | output | 1 | Radio keep-on output |
| blank_hr_tens | output | 1 | Blank the leading hour-tens digit |

## Verification
Every state bit appears directly on the outputs, so a wrong load, borrow or clear shows on the digit outputs one edge after the stimulus that caused it. A wrong zero test shows as `sleep_on` disagreeing with the digits in that same cycle. A missed edge detection only shows when the view is entered again, so the stimulus toggles `sleep_view` often. The bench's reference model compares the full value on every clock.

// File: rtl/sleep_down_timer.sv
module sleep_down_timer #(
  parameter int TENS_W = 3,
  parameter int ONES_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_view,
  input  logic              hour_btn,
  input  logic              min_btn,
  input  logic              snooze_btn,
  input  logic              alarm_on,
  input  logic              min_tick,
  input  logic              tick_2hz,
  output logic              hours,
  output logic [TENS_W-1:0] min_tens,
  output logic [ONES_W-1:0] min_ones,
  output logic              sleep_on,
  output logic              blank_hr_tens
);

  logic view_q;
  logic entry, clear, fast, step, nonzero;

  assign entry         = sleep_view & ~view_q;
  assign clear         = snooze_btn & ~alarm_on;
  assign fast          = sleep_view & min_btn & tick_2hz;
  assign nonzero       = hours | (min_tens != '0) | (min_ones != '0);
  assign step          = (fast | min_tick) & nonzero;
  assign sleep_on      = nonzero;
  assign blank_hr_tens = sleep_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      view_q   <= 1'b0;
      hours    <= 1'b0;
      min_tens <= '0;
      min_ones <= '0;
    end else begin
      view_q <= sleep_view;
      if (clear) begin
        hours    <= 1'b0;
        min_tens <= '0;
        min_ones <= '0;
      end else if (entry) begin
        hours    <= hour_btn;
        min_tens <= TENS_W'(5);
        min_ones <= ONES_W'(9);
      end else if (step) begin
        if (min_ones != '0) begin
          min_ones <= min_ones - 1'b1;
        end else if (min_tens != '0) begin
          min_tens <= min_tens - 1'b1;
          min_ones <= ONES_W'(9);
        end else begin
          hours    <= 1'b0;
          min_tens <= TENS_W'(5);
          min_ones <= ONES_W'(9);
        end
      end
    end
  end

  // R1
  entry_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && !clear && !hour_btn) |=> (!hours && min_tens == 5 && min_ones == 9));

  // R2
  entry_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && !clear && hour_btn) |=> (hours && min_tens == 5 && min_ones == 9));

  // R6
  snooze_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !sleep_on);

  // R8
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_on && !entry) |=> !sleep_on);

  // R9
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (min_tens <= 5 && min_ones <= 9));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry && !clear && !min_tick && !(sleep_view && min_btn && tick_2hz))
      |=> ($stable(hours) && $stable(min_tens) && $stable(min_ones)));

endmodule

// File: tb/test_sleep_down_timer.sv
module test_sleep_down_timer;
  logic clk = 0;
  logic rst_n = 0;
  logic sleep_view = 0, hour_btn = 0, min_btn = 0, snooze_btn = 0;
  logic alarm_on = 0, min_tick = 0, tick_2hz = 0;
  logic hours, sleep_on, blank_hr_tens;
  logic [2:0] min_tens;
  logic [3:0] min_ones;

  int checks = 0;
  int errors = 0;
  int model_min = 0;
  bit model_prev = 0;
  bit done = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sleep_down_timer i_sleep_down_timer (
    .clk(clk), .rst_n(rst_n), .sleep_view(sleep_view), .hour_btn(hour_btn),
    .min_btn(min_btn), .snooze_btn(snooze_btn), .alarm_on(alarm_on),
    .min_tick(min_tick), .tick_2hz(tick_2hz), .hours(hours),
    .min_tens(min_tens), .min_ones(min_ones), .sleep_on(sleep_on),
    .blank_hr_tens(blank_hr_tens));

  function automatic int dut_min();
    return int'(hours) * 60 + int'(min_tens) * 10 + int'(min_ones);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_min = 0;
      model_prev = 0;
    end else begin
      if (snooze_btn && !alarm_on) model_min = 0;
      else if (sleep_view && !model_prev) model_min = hour_btn ? 119 : 59;
      else if (((sleep_view && min_btn && tick_2hz) || min_tick) && model_min > 0)
        model_min = model_min - 1;
      model_prev = sleep_view;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk("R4 model value", dut_min(), model_min);
      chk("R5 model output", int'(sleep_on), int'(model_min != 0));
      chk("R10 model blank", int'(blank_hr_tens), int'(sleep_view));
    end
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_min();
    min_tick = 1; wait_n(1); min_tick = 0; wait_n(1);
  endtask

  task automatic pulse_fast(int n);
    for (int i = 0; i < n; i++) begin
      tick_2hz = 1; wait_n(1); tick_2hz = 0; wait_n(1);
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    wait_n(3);
    chk("R5 reset value", dut_min(), 0);
    chk("R5 reset output", int'(sleep_on), 0);
    chk("R10 reset blank", int'(blank_hr_tens), 0);
    rst_n = 1;
    wait_n(2);

    sleep_view = 1; wait_n(1);
    chk("R1 short preset", dut_min(), 59);
    chk("R10 blank in view", int'(blank_hr_tens), 1);
    chk("R5 output on", int'(sleep_on), 1);

    pulse_min();
    chk("R4 minute step", dut_min(), 58);

    sleep_view = 0; wait_n(1);
    hour_btn = 1; sleep_view = 1; wait_n(1);
    chk("R2 long preset", dut_min(), 119);

    pulse_fast(3);
    chk("R11 hour alone", dut_min(), 119);
    hour_btn = 0;

    min_btn = 1; pulse_fast(59); min_btn = 0;
    chk("R3 fast count", dut_min(), 60);
    chk("R9 hour digit", int'(hours), 1);
    pulse_min();
    chk("R9 borrow", dut_min(), 59);
    chk("R9 tens", int'(min_tens), 5);
    chk("R9 ones", int'(min_ones), 9);

    hour_btn = 1; min_btn = 1; pulse_fast(2); hour_btn = 0; min_btn = 0;
    chk("R3 both buttons", dut_min(), 57);

    min_tick = 1; tick_2hz = 1; min_btn = 1; wait_n(1);
    min_tick = 0; tick_2hz = 0; min_btn = 0; wait_n(1);
    chk("R4 single step", dut_min(), 56);

    alarm_on = 1; snooze_btn = 1; wait_n(1); snooze_btn = 0; wait_n(1);
    chk("R7 snooze ignored", dut_min(), 56);
    alarm_on = 0;

    snooze_btn = 1; wait_n(1); snooze_btn = 0;
    chk("R6 snooze clear", dut_min(), 0);
    chk("R6 output off", int'(sleep_on), 0);

    pulse_min();
    chk("R8 floor minute", dut_min(), 0);
    min_btn = 1; pulse_fast(2); min_btn = 0;
    chk("R8 floor fast", dut_min(), 0);

    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sleep_view = (lfsr[7:0] < 8'd240) ? sleep_view : ~sleep_view;
      hour_btn   = lfsr[3] & lfsr[9];
      min_btn    = lfsr[5];
      snooze_btn = (lfsr[11:8] == 4'hF);
      alarm_on   = lfsr[14];
      min_tick   = (lfsr[15:12] == 4'h3);
      tick_2hz   = lfsr[1] & lfsr[2];
      wait_n(1);
    end
    sleep_view = 0; hour_btn = 0; min_btn = 0; snooze_btn = 0;
    alarm_on = 0; min_tick = 0; tick_2hz = 0;
    wait_n(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule